// File: doc/BRIEF.md
# Paged RGB White Balance Lookup Stage

This block sits in a video pixel path and remaps every colour component of a 24-bit pixel through its own table. There are three tables, one each for red, green and blue. Each has one entry for every possible 8-bit component value, and the entry replaces the component it is indexed by. When correction is switched off, pixels pass through unchanged. Valid and the display timing strobes are delayed by the same two cycles in both modes, so the stage can be inserted without retiming its neighbours.

A small register-style host port reaches both the tables and a control byte. The control byte chooses which page the paged address window shows: the configuration space, or one of the three tables. It also holds the correction enable and a reload permit. Host writes always land in shadow tables. The shadow contents reach the active tables only on a rising edge of `frame_start` while reload is permitted, so a frame never mixes old and new entries. A ninth address bit reaches the configuration space whatever page is selected. This guarantees there is always a way back to the control byte.

Top module: `rgb_wb_lut`

## Requirements
- R1: The control byte lives at configuration offset 0x2A. It is reached with `host_addr[8]`=1 and low bits 0x2A on any page, or with `host_addr[8]`=0 and low bits 0x2A while the page is configuration. Every other configuration offset reads as 0x00 and ignores writes. On a table page, window offset 0x2A is an ordinary table entry.
- R2: Control byte fields are as follows. Bits 7:6 are the page: 00 configuration, 01 red, 10 green, 11 blue. Bit 5 is the correction enable (1 = on). Bit 4 is the reload permit (1 = permitted). Bits 3:0 always read 0 whatever is written.
- R3: When the page is 01, 10 or 11 and `host_addr[8]`=0, a window access at offset N writes or reads shadow entry N of the red, green or blue table respectively. The other tables are left untouched.
- R4: With correction on, the output red (bits 23:16), green (15:8) and blue (7:0) each equal the active entry of their own table, indexed by that component's input value.
- R5: Reset, which is synchronous and active high, clears the control byte to 0x00 and drives `out_vld`, `out_sync` and `out_pix` to 0. It also loads both the shadow and the active tables with the identity mapping (entry N holds N).
- R6: On a clock edge where `frame_start` is 1, it was 0 at the previous edge, and reload is permitted, the shadow tables are copied to the active tables. Pixels sampled at that edge and later use the new contents. Shadow writes made after the copy have no effect until the next such edge.
- R7: With correction off, `out_pix` equals the input pixel unchanged, whatever the table contents.
- R8: `out_vld`, `out_sync` and `out_pix` appear exactly 2 clock edges after the input is sampled, in both modes. The enable used for a pixel is the one in force at the edge that samples it.
- R9: A rising `frame_start` while reload is not permitted leaves the active tables unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 9 | Bit 8 selects the configuration space; bits 7:0 are the window offset |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for `host_addr`, combinational |
| frame_start | input | 1 | Frame boundary marker; its rising edge can commit the shadow tables |
| in_vld | input | 1 | Input pixel valid |
| in_sync | input | 3 | Timing strobes carried alongside the pixel |
| in_pix | input | 24 | Input pixel, red 23:16, green 15:8, blue 7:0 |
| out_vld | output | 1 | Output pixel valid |
| out_sync | output | 3 | Timing strobes, delayed to match the pixel |
| out_pix | output | 24 | Corrected or bypassed pixel |

## Verification
Pixel results are due two rising edges after the edge that samples the input. The driver therefore stamps each expected item with the current edge count plus two. The monitor, sampling one nanosecond after each edge, compares only the item whose stamp matches that edge, so early, late or missing outputs are all caught. Host read data is combinational and is checked within the same cycle in which the address is applied. A control or table write takes effect at the edge that performs it, so the first pixel driven after a host task already sees it. A commit happens at the edge that samples the rising `frame_start`, so the model updates its active tables before computing the expected value for the pixel driven alongside that edge.

// File: rtl/wb_lut_pkg.sv
package wb_lut_pkg;

    localparam int COMP_W   = 8;
    localparam int NUM_LANE = 3;
    localparam int SYNC_W   = 3;
    localparam int CTRL_OFS = 8'h2A;
    localparam int NO_LANE  = NUM_LANE;

    typedef enum logic [1:0] {
        PAGE_CFG = 2'b00,
        PAGE_RED = 2'b01,
        PAGE_GRN = 2'b10,
        PAGE_BLU = 2'b11
    } page_e;

    typedef struct packed {
        page_e      page;
        logic       enable;
        logic       reload;
        logic [3:0] spare;
    } ctrl_s;

    // Lane k holds pixel bits [k*COMP_W +: COMP_W]: lane 2 red, 1 green, 0 blue.
    function automatic int page_lane(page_e p);
        case (p)
            PAGE_RED: return 2;
            PAGE_GRN: return 1;
            PAGE_BLU: return 0;
            default:  return NO_LANE;
        endcase
    endfunction

endpackage

// File: rtl/wb_host_port.sv
module wb_host_port
    import wb_lut_pkg::*;
#(
    parameter int CW = COMP_W,
    parameter int NL = NUM_LANE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CW:0]       host_addr,
    input  logic              host_wr,
    input  logic [CW-1:0]     host_wdata,
    input  logic [NL*CW-1:0]  lane_rdata,
    output logic [CW-1:0]     host_rdata,
    output ctrl_s             ctrl_q,
    output logic [NL-1:0]     lane_wr,
    output logic [CW-1:0]     win_addr
);

    logic cfg_hit;
    logic ctrl_hit;
    int   sel_lane;

    assign win_addr = host_addr[CW-1:0];
    assign cfg_hit  = host_addr[CW] || (ctrl_q.page == PAGE_CFG);
    assign ctrl_hit = cfg_hit && (win_addr == CW'(CTRL_OFS));
    assign sel_lane = page_lane(ctrl_q.page);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (host_wr && ctrl_hit) begin
            ctrl_q <= {host_wdata[7:4], 4'b0000};
        end
    end

    for (genvar k = 0; k < NL; k++) begin : g_wr
        assign lane_wr[k] = host_wr && !cfg_hit && (sel_lane == k);
    end

    always_comb begin
        host_rdata = '0;
        if (cfg_hit) begin
            if (ctrl_hit) host_rdata = CW'(ctrl_q);
        end else begin
            for (int k = 0; k < NL; k++) begin
                if (sel_lane == k) host_rdata = lane_rdata[k*CW +: CW];
            end
        end
    end

    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (rst)
        (host_wr && ctrl_hit) |=> (ctrl_q == {$past(host_wdata[7:4]), 4'b0000})); // R2

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!host_wr) |=> $stable(ctrl_q)); // R1

endmodule

// File: rtl/wb_lane_table.sv
module wb_lane_table #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hw_en,
    input  logic [W-1:0] hw_addr,
    input  logic [W-1:0] hw_data,
    output logic [W-1:0] hr_data,
    input  logic         commit,
    input  logic [W-1:0] px_idx,
    output logic [W-1:0] px_out
);

    localparam int DEPTH = 1 << W;

    logic [W-1:0] shadow [DEPTH];
    logic [W-1:0] active [DEPTH];

    assign hr_data = shadow[hw_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                shadow[i] <= W'(i);
                active[i] <= W'(i);
            end
        end else begin
            if (hw_en) shadow[hw_addr] <= hw_data;
            if (commit) begin
                for (int i = 0; i < DEPTH; i++) active[i] <= shadow[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) px_out <= '0;
        else     px_out <= active[px_idx];
    end

    AST_SHADOW_WRITE: assert property (@(posedge clk) disable iff (rst)
        hw_en |=> (shadow[$past(hw_addr)] == $past(hw_data))); // R3

endmodule

// File: rtl/wb_align.sv
module wb_align #(
    parameter int W     = 8,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage[s] <= '0;
                else     stage[s] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage[s] <= '0;
                else     stage[s] <= stage[s-1];
            end
        end
    end

    assign dout = stage[DEPTH-1];

endmodule

// File: rtl/rgb_wb_lut.sv
module rgb_wb_lut
    import wb_lut_pkg::*;
#(
    parameter int CW = COMP_W,
    parameter int SW = SYNC_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [CW:0]             host_addr,
    input  logic                    host_wr,
    input  logic [CW-1:0]           host_wdata,
    output logic [CW-1:0]           host_rdata,
    input  logic                    frame_start,
    input  logic                    in_vld,
    input  logic [SW-1:0]           in_sync,
    input  logic [NUM_LANE*CW-1:0]  in_pix,
    output logic                    out_vld,
    output logic [SW-1:0]           out_sync,
    output logic [NUM_LANE*CW-1:0]  out_pix
);

    localparam int PW    = NUM_LANE * CW;
    localparam int TAP_W = 1 + SW + 1 + PW;

    ctrl_s              ctrl_q;
    logic [NUM_LANE-1:0] lane_wr;
    logic [CW-1:0]      win_addr;
    logic [PW-1:0]      lane_rdata;
    logic [PW-1:0]      lut_pix;
    logic               fs_q;
    logic               commit;
    logic [TAP_W-1:0]   tap_in, tap_s1, tap_s2;
    logic               s2_en;
    logic [PW-1:0]      s1_pix, s2_pix;
    logic [1:0]         age;

    wb_host_port #(.CW(CW), .NL(NUM_LANE)) u_host (
        .clk        (clk),
        .rst        (rst),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .lane_rdata (lane_rdata),
        .host_rdata (host_rdata),
        .ctrl_q     (ctrl_q),
        .lane_wr    (lane_wr),
        .win_addr   (win_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) fs_q <= 1'b0;
        else     fs_q <= frame_start;
    end

    assign commit = frame_start && !fs_q && ctrl_q.reload;

    assign tap_in = {in_vld, in_sync, ctrl_q.enable, in_pix};

    wb_align #(.W(TAP_W), .DEPTH(1)) u_s1 (
        .clk (clk), .rst (rst), .din (tap_in), .dout (tap_s1)
    );

    wb_align #(.W(TAP_W), .DEPTH(1)) u_s2 (
        .clk (clk), .rst (rst), .din (tap_s1), .dout (tap_s2)
    );

    assign s1_pix = tap_s1[PW-1:0];
    assign s2_pix = tap_s2[PW-1:0];
    assign s2_en  = tap_s2[PW];

    for (genvar k = 0; k < NUM_LANE; k++) begin : g_lane
        wb_lane_table #(.W(CW)) u_tbl (
            .clk     (clk),
            .rst     (rst),
            .hw_en   (lane_wr[k]),
            .hw_addr (win_addr),
            .hw_data (host_wdata),
            .hr_data (lane_rdata[k*CW +: CW]),
            .commit  (commit),
            .px_idx  (s1_pix[k*CW +: CW]),
            .px_out  (lut_pix[k*CW +: CW])
        );
    end

    assign out_pix  = s2_en ? lut_pix : s2_pix;
    assign out_sync = tap_s2[PW+1 +: SW];
    assign out_vld  = tap_s2[TAP_W-1];

    always_ff @(posedge clk) begin
        if (rst)            age <= 2'd0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    AST_VLD_DELAY: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2) |-> (out_vld == $past(in_vld, 2))); // R8

    AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2) |-> (out_sync == $past(in_sync, 2))); // R8

    AST_BYPASS_PIX: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2 && !$past(ctrl_q.enable, 2)) |-> (out_pix == $past(in_pix, 2))); // R7

endmodule

// File: tb/tb_rgb_wb_lut.sv
module tb_rgb_wb_lut;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [8:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        frame_start = 1'b0;
    logic        in_vld = 1'b0;
    logic [2:0]  in_sync = '0;
    logic [23:0] in_pix = '0;
    logic        out_vld;
    logic [2:0]  out_sync;
    logic [23:0] out_pix;

    always #4 clk = ~clk;

    rgb_wb_lut dut (
        .clk (clk), .rst (rst),
        .host_addr (host_addr), .host_wr (host_wr),
        .host_wdata (host_wdata), .host_rdata (host_rdata),
        .frame_start (frame_start),
        .in_vld (in_vld), .in_sync (in_sync), .in_pix (in_pix),
        .out_vld (out_vld), .out_sync (out_sync), .out_pix (out_pix)
    );

    typedef struct {
        int          due;
        logic        v;
        logic [2:0]  s;
        logic [23:0] p;
    } item_t;

    item_t q[$];
    string tagq[$];

    int   errors = 0;
    int   checks = 0;
    int   cyc = 0;
    logic live = 1'b0;
    logic done = 1'b0;

    // model: page 1 red, 2 green, 3 blue
    logic [7:0] shd [1:3][0:255];
    logic [7:0] act [1:3][0:255];
    logic [7:0] mctrl = 8'h00;
    logic       prev_fs = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // monitor
    always @(posedge clk) begin
        #1;
        if (live) begin
            if (q.size() > 0 && q[0].due == cyc) begin
                item_t it;
                string tg;
                it = q.pop_front();
                tg = tagq.pop_front();
                check({tg, " valid"}, {31'd0, out_vld}, {31'd0, it.v});
                check({tg, " sync"},  {29'd0, out_sync}, {29'd0, it.s});
                if (it.v) check({tg, " pixel"}, {8'd0, out_pix}, {8'd0, it.p});
            end else if (out_vld) begin
                check("R8 unexpected valid", {31'd0, out_vld}, 32'd0);
            end
        end
    end

    task automatic host_write(input logic [8:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        if (a[8] || mctrl[7:6] == 2'b00) begin
            if (a[7:0] == 8'h2A) mctrl = d & 8'hF0;
        end else begin
            shd[mctrl[7:6]][a[7:0]] = d;
        end
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input string tag, input logic [8:0] a, input logic [7:0] exp);
        @(negedge clk);
        host_addr = a; host_wr = 1'b0;
        #1;
        check(tag, {24'd0, host_rdata}, {24'd0, exp});
    endtask

    task automatic px(input string tag, input logic fs, input logic v,
                      input logic [2:0] s, input logic [23:0] p);
        item_t it;
        @(negedge clk);
        frame_start = fs; in_vld = v; in_sync = s; in_pix = p;
        if (fs && !prev_fs && mctrl[4]) begin
            for (int t = 1; t <= 3; t++)
                for (int i = 0; i < 256; i++) act[t][i] = shd[t][i];
        end
        prev_fs = fs;
        it.due = cyc + 2;
        it.v = v;
        it.s = s;
        it.p = mctrl[5] ? {act[1][p[23:16]], act[2][p[15:8]], act[3][p[7:0]]} : p;
        q.push_back(it);
        tagq.push_back(tag);
    endtask

    task automatic flush();
        for (int i = 0; i < 3; i++) px("R8 idle", 1'b0, 1'b0, 3'b000, 24'h0);
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int t = 1; t <= 3; t++)
            for (int i = 0; i < 256; i++) begin
                shd[t][i] = 8'(i);
                act[t][i] = 8'(i);
            end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        // R5 reset state
        check("R5 out_vld after reset", {31'd0, out_vld}, 32'd0);
        check("R5 out_pix after reset", {8'd0, out_pix}, 32'd0);
        check("R5 out_sync after reset", {29'd0, out_sync}, 32'd0);
        host_read("R5 control resets to 0", 9'h12A, 8'h00);
        host_read("R1 window on config page", 9'h02A, 8'h00);
        host_read("R1 other config offset", 9'h105, 8'h00);
        live = 1'b1;

        // R7 R8 bypass while disabled
        px("R7 bypass a", 1'b0, 1'b1, 3'b101, 24'h123456);
        px("R7 bypass b", 1'b0, 1'b1, 3'b010, 24'hA5FF00);
        px("R8 gap",      1'b0, 1'b0, 3'b111, 24'h000000);
        px("R7 bypass c", 1'b0, 1'b1, 3'b001, 24'h0000FF);
        flush();

        // R3 paged table writes
        host_write(9'h12A, 8'h40);
        host_write(9'h010, 8'hAA);
        host_read("R3 red entry readback", 9'h010, 8'hAA);
        host_read("R5 red identity entry", 9'h011, 8'h11);
        host_write(9'h12A, 8'h80);
        host_write(9'h010, 8'h3C);
        host_read("R3 green entry readback", 9'h010, 8'h3C);
        host_write(9'h12A, 8'hC0);
        host_write(9'h010, 8'h01);
        host_write(9'h02A, 8'h77);
        host_read("R3 blue entry readback", 9'h02A, 8'h77);
        host_read("R1 control unchanged by table write", 9'h12A, 8'hC0);
        host_write(9'h105, 8'hFF);
        host_read("R1 ignored config write", 9'h105, 8'h00);

        // R9 no commit without reload
        host_write(9'h12A, 8'hE0);
        px("R9 before edge", 1'b0, 1'b1, 3'b000, 24'h101010);
        px("R9 rising edge no reload", 1'b1, 1'b1, 3'b011, 24'h101010);
        px("R6 shadow not applied", 1'b0, 1'b1, 3'b000, 24'h10202A);
        flush();

        // R6 R4 commit with reload
        host_write(9'h12A, 8'hF0);
        px("R6 before commit", 1'b0, 1'b1, 3'b000, 24'h101010);
        px("R4 commit edge pixel", 1'b1, 1'b1, 3'b100, 24'h101010);
        px("R4 per lane lookup", 1'b1, 1'b1, 3'b000, 24'h10202A);
        flush();
        host_write(9'h12A, 8'h70);
        host_write(9'h010, 8'h55);
        px("R6 mid frame keeps old", 1'b0, 1'b1, 3'b000, 24'h101010);
        px("R6 next frame commits", 1'b1, 1'b1, 3'b000, 24'h101010);
        px("R4 identity elsewhere", 1'b0, 1'b1, 3'b010, 24'hFE0180);
        flush();

        // R2 reserved bits
        host_write(9'h12A, 8'hFF);
        host_read("R2 spare bits read zero", 9'h12A, 8'hF0);

        // R7 disable with modified tables
        host_write(9'h12A, 8'h10);
        px("R7 bypass with loaded tables", 1'b0, 1'b1, 3'b110, 24'h101010);
        flush();
        host_write(9'h02A, 8'h20);
        host_read("R1 window write on config page", 9'h12A, 8'h20);
        px("R4 re-enabled lookup", 1'b0, 1'b1, 3'b000, 24'h10102A);
        flush();
        repeat (4) @(negedge clk);
        check("R8 all items drained", q.size(), 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule